// File: doc/BRIEF.md
# Shifted-Operand ALU with Condition Gating

This block is the data-processing stage of a 32-bit integer pipeline. The first operand always comes from a register. The second operand is either a register value or an immediate. It passes through a barrel shifter (logical left, logical right, arithmetic right or rotate right, by 0 to 31 places) before it reaches the arithmetic and logic stage, and all of this happens in the same cycle. The block returns a result, a write enable for the destination register, and the next values of the four condition flags: negative, zero, carry and overflow.

Each operation carries a 4-bit condition code, which is tested against the incoming flags. When the condition fails, the operation is suppressed: no register write takes place and the flags pass through unchanged. Three comparison operations (subtract-compare, XOR-test and AND-test) can only affect the flags. Flags are updated only when the set-flags control is high. All outputs are registered, so they appear one clock after the inputs are presented.

Top module: `shop_alu`

## Requirements
- R1: The outputs `res_out`, `wr_en_out` and `flags_out` are registered and reflect the inputs present at the previous rising clock edge. While `rst` is high they are all zero.
- R2: `sh_kind` selects the shift: 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right, applied by `sh_amt` places (0 to 31). A left shift by n multiplies operand B by 2^n, and an amount of 0 leaves operand B unchanged.
- R3: `op_code` selects the operation: 0 move B, 1 move NOT B, 2 A+B, 3 A-B, 4 A AND B, 5 A OR B, 6 A XOR B, 7 A AND NOT B. Opcodes 0 to 7 assert `wr_en_out` when their condition passes.
- R4: `flags_in` and `flags_out` are packed as {N, Z, C, V} in bits 3 down to 0. For add, C is the carry out of bit 31. For subtract and compare, C is 1 when no borrow occurs. For add, subtract and compare, V is signed overflow.
- R5: For move, move-inverted, AND, OR, XOR, bit clear, XOR-test and AND-test, C takes the last bit shifted out by the shifter, or keeps its incoming value when the shift amount is 0, and V keeps its incoming value.
- R6: Opcodes 8 (flags from A-B), 9 (flags from A XOR B) and 10 (flags from A AND B) never assert `wr_en_out`.
- R7: When `set_flags` is low, `flags_out` equals `flags_in`.
- R8: `cond` values 0 to 15 mean EQ, NE, CS, CC, MI, PL, VS, VC, HI, LS, GE, LT, GT, LE, always and never. A failing condition deasserts `wr_en_out` and passes `flags_in` through unchanged.
- R9: Opcodes 11 to 15 never write and never change the flags.
- R10: `use_imm` high selects `b_imm` as the shifter input; `use_imm` low selects `b_reg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 4 | Operation select |
| set_flags | input | 1 | Allow flag update |
| cond | input | 4 | Condition code gating the operation |
| a_val | input | 32 | First operand (register) |
| b_reg | input | 32 | Second operand, register source |
| b_imm | input | 32 | Second operand, immediate source |
| use_imm | input | 1 | Select immediate for operand B |
| sh_kind | input | 2 | Shift type |
| sh_amt | input | 5 | Shift amount |
| flags_in | input | 4 | Current {N,Z,C,V} |
| res_out | output | 32 | Registered result |
| wr_en_out | output | 1 | Registered destination write enable |
| flags_out | output | 4 | Registered next {N,Z,C,V} |

## Verification
Additions are tried at the signed overflow point and at the unsigned wrap point, which separates V from C. Subtractions are tried with and without a borrow, which shows that C is the inverted borrow. Each shift kind is run on an operand with set top and bottom bits, so a wrong shift-out bit shows up in C, and a zero amount shows that C is carried through. Every condition code is swept against all sixteen flag combinations, and compare, set-flags-low and reserved-opcode vectors are run with inputs that would visibly change the flags or write if gating failed.

// File: rtl/shop_alu_pkg.sv
package shop_alu_pkg;
  localparam logic [3:0] OP_MOVE = 4'd0;
  localparam logic [3:0] OP_MOVN = 4'd1;
  localparam logic [3:0] OP_ADD  = 4'd2;
  localparam logic [3:0] OP_SUB  = 4'd3;
  localparam logic [3:0] OP_AND  = 4'd4;
  localparam logic [3:0] OP_ORR  = 4'd5;
  localparam logic [3:0] OP_XOR  = 4'd6;
  localparam logic [3:0] OP_BCLR = 4'd7;
  localparam logic [3:0] OP_CMP  = 4'd8;
  localparam logic [3:0] OP_TXR  = 4'd9;
  localparam logic [3:0] OP_TAND = 4'd10;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shift_kind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;
endpackage

// File: rtl/shop_alu_shifter.sv
module shop_alu_shifter #(
  parameter int W = 32,
  localparam int SHW = $clog2(W)
) (
  input  logic [W-1:0]   din,
  input  logic [1:0]     kind,
  input  logic [SHW-1:0] amt,
  input  logic           carry_in,
  output logic [W-1:0]   dout,
  output logic           carry_out
);
  import shop_alu_pkg::*;

  logic [W:0]          left_ext;
  logic [W:0]          right_ext;
  logic signed [W:0]   arith_ext;
  logic [2*W-1:0]      rot_ext;

  always_comb begin
    left_ext  = {1'b0, din} << amt;
    right_ext = {din, 1'b0} >> amt;
    arith_ext = $signed({din, 1'b0}) >>> amt;
    rot_ext   = {din, din} >> amt;
    if (amt == '0) begin
      dout      = din;
      carry_out = carry_in;
    end else begin
      unique case (shift_kind_e'(kind))
        SH_LSL: begin
          dout      = left_ext[W-1:0];
          carry_out = left_ext[W];
        end
        SH_LSR: begin
          dout      = right_ext[W:1];
          carry_out = right_ext[0];
        end
        SH_ASR: begin
          dout      = arith_ext[W:1];
          carry_out = arith_ext[0];
        end
        default: begin
          dout      = rot_ext[W-1:0];
          carry_out = rot_ext[W-1];
        end
      endcase
    end
  end
endmodule

// File: rtl/shop_alu_cond.sv
module shop_alu_cond (
  input  logic [3:0]          cc,
  input  shop_alu_pkg::nzcv_t fl,
  output logic                pass
);
  always_comb begin
    unique case (cc)
      4'd0:    pass = fl.z;
      4'd1:    pass = !fl.z;
      4'd2:    pass = fl.c;
      4'd3:    pass = !fl.c;
      4'd4:    pass = fl.n;
      4'd5:    pass = !fl.n;
      4'd6:    pass = fl.v;
      4'd7:    pass = !fl.v;
      4'd8:    pass = fl.c && !fl.z;
      4'd9:    pass = !fl.c || fl.z;
      4'd10:   pass = (fl.n == fl.v);
      4'd11:   pass = (fl.n != fl.v);
      4'd12:   pass = !fl.z && (fl.n == fl.v);
      4'd13:   pass = fl.z || (fl.n != fl.v);
      4'd14:   pass = 1'b1;
      default: pass = 1'b0;
    endcase
  end
endmodule

// File: rtl/shop_alu_exec.sv
module shop_alu_exec #(
  parameter int W = 32
) (
  input  logic [3:0]          op,
  input  logic [W-1:0]        a,
  input  logic [W-1:0]        b,
  input  logic                sh_c,
  input  shop_alu_pkg::nzcv_t fl_in,
  output logic [W-1:0]        result,
  output logic                writes,
  output logic                known,
  output shop_alu_pkg::nzcv_t fl_new
);
  import shop_alu_pkg::*;

  logic [W:0] sum_ext;
  logic [W:0] diff_ext;
  logic       arith;
  logic       carry_a;
  logic       ovf_a;

  always_comb begin
    sum_ext  = {1'b0, a} + {1'b0, b};
    diff_ext = {1'b0, a} - {1'b0, b};
    arith    = 1'b0;
    carry_a  = 1'b0;
    ovf_a    = 1'b0;
    writes   = 1'b1;
    known    = 1'b1;
    result   = '0;
    unique case (op)
      OP_MOVE: result = b;
      OP_MOVN: result = ~b;
      OP_ADD: begin
        result  = sum_ext[W-1:0];
        arith   = 1'b1;
        carry_a = sum_ext[W];
        ovf_a   = (a[W-1] == b[W-1]) && (sum_ext[W-1] != a[W-1]);
      end
      OP_SUB, OP_CMP: begin
        result  = diff_ext[W-1:0];
        arith   = 1'b1;
        carry_a = ~diff_ext[W];
        ovf_a   = (a[W-1] != b[W-1]) && (diff_ext[W-1] != a[W-1]);
        writes  = (op == OP_SUB);
      end
      OP_AND:  result = a & b;
      OP_ORR:  result = a | b;
      OP_XOR:  result = a ^ b;
      OP_BCLR: result = a & ~b;
      OP_TXR: begin
        result = a ^ b;
        writes = 1'b0;
      end
      OP_TAND: begin
        result = a & b;
        writes = 1'b0;
      end
      default: begin
        writes = 1'b0;
        known  = 1'b0;
      end
    endcase
    fl_new.n = result[W-1];
    fl_new.z = (result == '0);
    fl_new.c = arith ? carry_a : sh_c;
    fl_new.v = arith ? ovf_a : fl_in.v;
  end
endmodule

// File: rtl/shop_alu.sv
module shop_alu #(
  parameter int W = 32,
  localparam int SHW = $clog2(W)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [3:0]     op_code,
  input  logic           set_flags,
  input  logic [3:0]     cond,
  input  logic [W-1:0]   a_val,
  input  logic [W-1:0]   b_reg,
  input  logic [W-1:0]   b_imm,
  input  logic           use_imm,
  input  logic [1:0]     sh_kind,
  input  logic [SHW-1:0] sh_amt,
  input  logic [3:0]     flags_in,
  output logic [W-1:0]   res_out,
  output logic           wr_en_out,
  output logic [3:0]     flags_out
);
  import shop_alu_pkg::*;

  nzcv_t      cur_fl;
  nzcv_t      new_fl;
  logic [W-1:0] b_src;
  logic [W-1:0] b_shifted;
  logic         sh_carry;
  logic         cond_ok;
  logic [W-1:0] alu_res;
  logic         alu_writes;
  logic         alu_known;

  assign cur_fl = nzcv_t'(flags_in);
  assign b_src  = use_imm ? b_imm : b_reg;

  shop_alu_shifter #(.W(W)) shifter_i (
    .din      (b_src),
    .kind     (sh_kind),
    .amt      (sh_amt),
    .carry_in (cur_fl.c),
    .dout     (b_shifted),
    .carry_out(sh_carry)
  );

  shop_alu_cond cond_i (
    .cc  (cond),
    .fl  (cur_fl),
    .pass(cond_ok)
  );

  shop_alu_exec #(.W(W)) exec_i (
    .op    (op_code),
    .a     (a_val),
    .b     (b_shifted),
    .sh_c  (sh_carry),
    .fl_in (cur_fl),
    .result(alu_res),
    .writes(alu_writes),
    .known (alu_known),
    .fl_new(new_fl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_out   <= '0;
      wr_en_out <= 1'b0;
      flags_out <= '0;
    end else begin
      res_out   <= alu_res;
      wr_en_out <= cond_ok && alu_writes;
      flags_out <= (cond_ok && set_flags && alu_known) ? new_fl : flags_in;
    end
  end
endmodule

// File: rtl/shop_alu_chk.sv
module shop_alu_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [3:0]   op_code,
  input logic         set_flags,
  input logic [3:0]   cond,
  input logic [3:0]   flags_in,
  input logic [W-1:0] res_out,
  input logic         wr_en_out,
  input logic [3:0]   flags_out
);
  assert_cmp_no_write_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(op_code) == 4'd8 || $past(op_code) == 4'd9 || $past(op_code) == 4'd10)
      |-> !wr_en_out);

  assert_flags_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(set_flags)) |-> (flags_out == $past(flags_in)));

  assert_never_cond_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cond) == 4'd15) |-> (!wr_en_out && flags_out == $past(flags_in)));

  assert_always_writes_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cond) == 4'd14 && $past(op_code) <= 4'd7) |-> wr_en_out);

  assert_reserved_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_code) >= 4'd11) |-> (!wr_en_out && flags_out == $past(flags_in)));

  assert_nz_match_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(set_flags) && $past(cond) == 4'd14 && $past(op_code) <= 4'd10)
      |-> (flags_out[2] == (res_out == '0) && flags_out[3] == res_out[W-1]));

  assert_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> (res_out == '0 && !wr_en_out && flags_out == 4'd0));
endmodule

bind shop_alu shop_alu_chk #(.W(W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .op_code  (op_code),
  .set_flags(set_flags),
  .cond     (cond),
  .flags_in (flags_in),
  .res_out  (res_out),
  .wr_en_out(wr_en_out),
  .flags_out(flags_out)
);

// File: tb/shop_alu_tb_top.sv
`timescale 1ns/1ps
module shop_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_code = '0;
  logic        set_flags = 1'b0;
  logic [3:0]  cond = 4'd14;
  logic [31:0] a_val = '0;
  logic [31:0] b_reg = '0;
  logic [31:0] b_imm = '0;
  logic        use_imm = 1'b0;
  logic [1:0]  sh_kind = '0;
  logic [4:0]  sh_amt = '0;
  logic [3:0]  flags_in = '0;
  logic [31:0] res_out;
  logic        wr_en_out;
  logic [3:0]  flags_out;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  shop_alu dut_i (
    .clk(clk), .rst(rst), .op_code(op_code), .set_flags(set_flags), .cond(cond),
    .a_val(a_val), .b_reg(b_reg), .b_imm(b_imm), .use_imm(use_imm),
    .sh_kind(sh_kind), .sh_amt(sh_amt), .flags_in(flags_in),
    .res_out(res_out), .wr_en_out(wr_en_out), .flags_out(flags_out)
  );

  task automatic drive(input logic [3:0] op, input logic sf, input logic [3:0] cc,
                       input logic [31:0] a, input logic [31:0] br, input logic [31:0] bi,
                       input logic ui, input logic [1:0] k, input logic [4:0] amt,
                       input logic [3:0] fl);
    @(negedge clk);
    op_code = op; set_flags = sf; cond = cc; a_val = a; b_reg = br; b_imm = bi;
    use_imm = ui; sh_kind = k; sh_amt = amt; flags_in = fl;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input string tag, input bit chk_res, input logic [31:0] er,
                            input logic ewe, input logic [3:0] ef);
    n_vec++;
    if ((chk_res && res_out !== er) || wr_en_out !== ewe || flags_out !== ef) begin
      n_bad++;
      $display("FAIL %s: res=%h we=%b fl=%b expected res=%h we=%b fl=%b",
               tag, res_out, wr_en_out, flags_out, er, ewe, ef);
    end
  endtask

  function automatic logic cond_ref(input logic [3:0] cc, input logic [3:0] f);
    logic n, z, c, v;
    {n, z, c, v} = f;
    case (cc)
      4'd0: return z;            4'd1: return !z;
      4'd2: return c;            4'd3: return !c;
      4'd4: return n;            4'd5: return !n;
      4'd6: return v;            4'd7: return !v;
      4'd8: return c & !z;       4'd9: return !c | z;
      4'd10: return n == v;      4'd11: return n != v;
      4'd12: return !z & (n == v);
      4'd13: return z | (n != v);
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic t_reset;
    repeat (2) @(posedge clk);
    #1;
    expect_out("R1 reset", 1'b1, 32'h0, 1'b0, 4'b0000);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_shifts;
    drive(4'd0, 1'b0, 4'd14, 0, 32'd5, 0, 1'b0, 2'd0, 5'd2, 4'b0000);
    expect_out("R2 lsl2 x4", 1'b1, 32'd20, 1'b1, 4'b0000);
    drive(4'd0, 1'b1, 4'd14, 0, 32'h8000_0001, 0, 1'b0, 2'd1, 5'd1, 4'b0001);
    expect_out("R5 lsr carry", 1'b1, 32'h4000_0000, 1'b1, 4'b0011);
    drive(4'd0, 1'b1, 4'd14, 0, 32'h8000_0001, 0, 1'b0, 2'd0, 5'd1, 4'b0000);
    expect_out("R5 lsl carry", 1'b1, 32'h0000_0002, 1'b1, 4'b0010);
    drive(4'd0, 1'b1, 4'd14, 0, 32'h8000_0010, 0, 1'b0, 2'd2, 5'd4, 4'b0010);
    expect_out("R2 asr", 1'b1, 32'hF800_0001, 1'b1, 4'b1000);
    drive(4'd0, 1'b1, 4'd14, 0, 32'h1234_5678, 0, 1'b0, 2'd3, 5'd4, 4'b0000);
    expect_out("R2 ror", 1'b1, 32'h8123_4567, 1'b1, 4'b1010);
    drive(4'd2, 1'b0, 4'd14, 32'd7, 32'd7, 0, 1'b0, 2'd0, 5'd1, 4'b0000);
    expect_out("R2 add shifted", 1'b1, 32'd21, 1'b1, 4'b0000);
  endtask

  task automatic t_logic;
    drive(4'd1, 1'b1, 4'd14, 0, 32'h0000_00FF, 0, 1'b0, 2'd0, 5'd0, 4'b0011);
    expect_out("R5 mvn keeps C,V", 1'b1, 32'hFFFF_FF00, 1'b1, 4'b1011);
    drive(4'd4, 1'b0, 4'd14, 32'hF0F0_1234, 32'h0FF0_FF00, 0, 1'b0, 2'd0, 5'd0, 4'b0000);
    expect_out("R3 and", 1'b1, 32'h00F0_1200, 1'b1, 4'b0000);
    drive(4'd5, 1'b0, 4'd14, 32'hF0F0_1234, 32'h0FF0_FF00, 0, 1'b0, 2'd0, 5'd0, 4'b0000);
    expect_out("R3 orr", 1'b1, 32'hFFF0_FF34, 1'b1, 4'b0000);
    drive(4'd6, 1'b0, 4'd14, 32'hF0F0_1234, 32'h0FF0_FF00, 0, 1'b0, 2'd0, 5'd0, 4'b0000);
    expect_out("R3 xor", 1'b1, 32'hFF00_ED34, 1'b1, 4'b0000);
    drive(4'd7, 1'b0, 4'd14, 32'hF0F0_1234, 32'h0FF0_FF00, 0, 1'b0, 2'd0, 5'd0, 4'b0000);
    expect_out("R3 bit clear", 1'b1, 32'hF000_0034, 1'b1, 4'b0000);
  endtask

  task automatic t_arith;
    drive(4'd2, 1'b1, 4'd14, 32'h7FFF_FFFF, 0, 32'd1, 1'b1, 2'd0, 5'd0, 4'b0000);
    expect_out("R4 add overflow", 1'b1, 32'h8000_0000, 1'b1, 4'b1001);
    drive(4'd2, 1'b1, 4'd14, 32'hFFFF_FFFF, 0, 32'd1, 1'b1, 2'd0, 5'd0, 4'b0000);
    expect_out("R4 add carry", 1'b1, 32'h0, 1'b1, 4'b0110);
    drive(4'd3, 1'b1, 4'd14, 32'd3, 32'd5, 0, 1'b0, 2'd0, 5'd0, 4'b0010);
    expect_out("R4 sub borrow", 1'b1, 32'hFFFF_FFFE, 1'b1, 4'b1000);
    drive(4'd3, 1'b1, 4'd14, 32'd5, 32'd3, 0, 1'b0, 2'd0, 5'd0, 4'b0000);
    expect_out("R4 sub no borrow", 1'b1, 32'd2, 1'b1, 4'b0010);
    drive(4'd2, 1'b0, 4'd14, 32'h7FFF_FFFF, 32'd1, 0, 1'b0, 2'd0, 5'd0, 4'b1010);
    expect_out("R7 no set flags", 1'b1, 32'h8000_0000, 1'b1, 4'b1010);
  endtask

  task automatic t_operand_sel;
    drive(4'd0, 1'b0, 4'd14, 0, 32'h1111_1111, 32'h2222_2222, 1'b1, 2'd0, 5'd0, 4'b0000);
    expect_out("R10 immediate", 1'b1, 32'h2222_2222, 1'b1, 4'b0000);
    drive(4'd0, 1'b0, 4'd14, 0, 32'h1111_1111, 32'h2222_2222, 1'b0, 2'd0, 5'd0, 4'b0000);
    expect_out("R10 register", 1'b1, 32'h1111_1111, 1'b1, 4'b0000);
  endtask

  task automatic t_compare;
    drive(4'd8, 1'b1, 4'd14, 32'd5, 32'd5, 0, 1'b0, 2'd0, 5'd0, 4'b1000);
    expect_out("R6 cmp", 1'b0, 0, 1'b0, 4'b0110);
    drive(4'd9, 1'b1, 4'd14, 32'hA, 32'hA, 0, 1'b0, 2'd0, 5'd0, 4'b0001);
    expect_out("R6 teq", 1'b0, 0, 1'b0, 4'b0101);
    drive(4'd10, 1'b1, 4'd14, 32'hF0, 32'h0F, 0, 1'b0, 2'd0, 5'd0, 4'b1000);
    expect_out("R6 tst", 1'b0, 0, 1'b0, 4'b0100);
  endtask

  task automatic t_cond;
    drive(4'd2, 1'b1, 4'd0, 32'd1, 32'd1, 0, 1'b0, 2'd0, 5'd0, 4'b0000);
    expect_out("R8 eq fails", 1'b0, 0, 1'b0, 4'b0000);
    drive(4'd2, 1'b1, 4'd0, 32'd1, 32'd1, 0, 1'b0, 2'd0, 5'd0, 4'b0100);
    expect_out("R8 eq passes", 1'b1, 32'd2, 1'b1, 4'b0000);
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        drive(4'd0, 1'b0, c[3:0], 0, 32'd9, 0, 1'b0, 2'd0, 5'd0, f[3:0]);
        expect_out("R8 cond table", 1'b0, 0, cond_ref(c[3:0], f[3:0]), f[3:0]);
      end
    end
  endtask

  task automatic t_reserved;
    for (int o = 11; o < 16; o++) begin
      drive(o[3:0], 1'b1, 4'd14, 32'd0, 32'd0, 0, 1'b0, 2'd0, 5'd0, 4'b1011);
      expect_out("R9 reserved op", 1'b0, 0, 1'b0, 4'b1011);
    end
  endtask

  initial begin
    t_reset();
    t_shifts();
    t_logic();
    t_arith();
    t_operand_sel();
    t_compare();
    t_cond();
    t_reserved();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule